// File: doc/BRIEF.md
# SPI Slave Hold-Condition Controller

This block sits between the pins of an SPI slave and its internal shift logic. It lets the master pause a transfer in the middle of a frame without deselecting the slave. It watches three pins: the active-low select, the serial clock and an active-low pause request. It turns them into three kinds of output:

- qualified clock-edge strobes for the shifter,
- a level shift-enable that freezes the bit counter and shift register while paused,
- an output enable for the serial data-out pin.

All pins are sampled in one fast system-clock domain through synchronisers. The block detects serial-clock levels and edges from the synchronised samples.

A pause starts or ends only while the synchronised serial clock is low. A request that arrives during the high phase waits for the next low phase. This prevents a half-shifted bit. Raising the select at any time ends the frame, including during a pause. The downstream logic receives a one-cycle frame reset. A new frame then starts only once the select is low and the pause request is released.

Top module: `spi_hold_ctrl`

## Requirements
- R1: After reset, shift_en_o, so_oe_o, held_o, frame_rst_o, sck_rise_o and sck_fall_o are all 0.
- R2: With cs_n_i low and hold_n_i high, the frame becomes active: shift_en_o and so_oe_o go to 1. Each sck_i rising edge gives exactly one sck_rise_o pulse, and each falling edge gives exactly one sck_fall_o pulse.
- R3: While cs_n_i is low and hold_n_i is low, no frame starts after a deselect. shift_en_o stays 0 and no strobes appear until hold_n_i goes high.
- R4: In an active frame, hold_n_i low while sck_i is low enters the pause. held_o goes to 1, and shift_en_o and so_oe_o go to 0. The pause lasts as long as hold_n_i stays low.
- R5: If hold_n_i falls while sck_i is high, the pause is deferred. held_o stays 0 and shift_en_o stays 1 until sck_i goes low. The sck_i falling edge that ends that high phase still produces its sck_fall_o pulse.
- R6: While paused, sck_i edges produce no sck_rise_o or sck_fall_o pulses.
- R7: The pause ends when hold_n_i is high while sck_i is low. If hold_n_i rises while sck_i is high, the pause lasts until sck_i goes low, and that falling edge gives no strobe.
- R8: cs_n_i going high during an active or paused frame gives exactly one frame_rst_o pulse and returns all enables and held_o to 0. cs_n_i high while already idle gives no pulse.
- R9: so_o equals so_data_i while so_oe_o is 1 and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the SPI pins |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n_i | input | 1 | Slave select pin, active low |
| sck_i | input | 1 | Serial clock pin |
| hold_n_i | input | 1 | Pause request pin, active low |
| so_data_i | input | 1 | Data bit from the shifter for the data-out pin |
| shift_en_o | output | 1 | High while the frame is active and not paused |
| sck_rise_o | output | 1 | One-cycle strobe per qualified serial clock rising edge |
| sck_fall_o | output | 1 | One-cycle strobe per qualified serial clock falling edge |
| held_o | output | 1 | High while the pause is in effect |
| frame_rst_o | output | 1 | One-cycle pulse when a selected frame is ended by deselect |
| so_o | output | 1 | Gated data-out value |
| so_oe_o | output | 1 | Output enable for the data-out pad driver |

## Verification
Two events can fall into the same system-clock cycle: the start of a deferred pause and the serial clock falling edge that ends the high phase. The bench provokes this by pulling the pause request low during a high phase of the clock and then dropping the clock. It then checks that the falling-edge count rose by exactly one and that held_o is set. The opposite coincidence is also provoked: a release during the high phase followed by a falling edge. Here the bench checks that no strobe is counted for that edge and that the next rising edge is counted. Deselect during a pause is driven as well, and the bench counts exactly one frame-reset pulse.

// File: rtl/spi_hold_pkg.sv
// Package: shared state encoding for the hold-condition controller.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package spi_hold_pkg;

    // Frame state: deselected, shifting, or paused mid-frame.
    typedef enum logic [1:0] {
        FRM_IDLE   = 2'd0,
        FRM_ACTIVE = 2'd1,
        FRM_PAUSED = 2'd2
    } frm_state_t;

    // Bit positions of the pin bundle passed through the synchroniser.
    localparam int unsigned PIN_CS   = 0;
    localparam int unsigned PIN_SCK  = 1;
    localparam int unsigned PIN_HOLD = 2;
    localparam int unsigned PIN_NUM  = 3;

endpackage

// File: rtl/spi_hold_sync.sv
// Module: multi-bit, multi-stage level synchroniser.
// Does: brings asynchronous pin levels into the clk domain.
// Assumes: each bit is an independent level, no multi-bit coherence is needed;
// RST_VAL holds the idle level of every pin.
module spi_hold_sync #(
    parameter int unsigned WIDTH   = 3,
    parameter int unsigned STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    localparam int unsigned LAST = STAGES - 1;

    logic [WIDTH-1:0] stg [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // Capture the raw pin levels.
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[g] <= RST_VAL;
                    else        stg[g] <= d_i;
                end
            end else begin : g_next
                // Pass the previous stage along the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[g] <= RST_VAL;
                    else        stg[g] <= stg[g-1];
                end
            end
        end
    endgenerate

    assign q_o = stg[LAST];

endmodule

// File: rtl/spi_hold_sck_edge.sv
// Module: serial clock edge detector.
// Does: turns the synchronised serial clock level into raw rise and fall strobes.
// Assumes: the input is already synchronised; the serial clock idles low at reset.
module spi_hold_sck_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_s_i,
    output logic rise_o,
    output logic fall_o
);

    logic sck_d;

    // Remember the previous synchronised level.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_d <= 1'b0;
        else        sck_d <= sck_s_i;
    end

    assign rise_o = sck_s_i & ~sck_d;
    assign fall_o = ~sck_s_i & sck_d;

endmodule

// File: rtl/spi_hold_fsm.sv
// Module: frame and pause state machine.
// Does: tracks idle / active / paused. Pause entry and exit happen only while the
// synchronised serial clock is low; deselect returns to idle from any state.
// Assumes: inputs are synchronised levels; hold_s_i and cs_s_i are active low.
module spi_hold_fsm
    import spi_hold_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_s_i,
    input  logic       sck_s_i,
    input  logic       hold_s_i,
    output frm_state_t state_o
);

    frm_state_t st, st_nxt;

    // Next-state selection.
    always_comb begin
        st_nxt = st;
        unique case (st)
            FRM_IDLE: begin
                if (!cs_s_i && hold_s_i) st_nxt = FRM_ACTIVE;
            end
            FRM_ACTIVE: begin
                if (cs_s_i)                       st_nxt = FRM_IDLE;
                else if (!hold_s_i && !sck_s_i)   st_nxt = FRM_PAUSED;
            end
            FRM_PAUSED: begin
                if (cs_s_i)                       st_nxt = FRM_IDLE;
                else if (hold_s_i && !sck_s_i)    st_nxt = FRM_ACTIVE;
            end
            default: st_nxt = FRM_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= FRM_IDLE;
        else        st <= st_nxt;
    end

    assign state_o = st;

    // R4
    pause_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == FRM_ACTIVE && !cs_s_i && !hold_s_i && !sck_s_i) |=> (st == FRM_PAUSED));

    // R4
    pause_persist_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == FRM_PAUSED && !cs_s_i && !hold_s_i) |=> (st == FRM_PAUSED));

    // R5
    no_entry_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == FRM_ACTIVE && sck_s_i) |=> (st != FRM_PAUSED));

    // R7
    no_exit_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == FRM_PAUSED && sck_s_i && !cs_s_i) |=> (st == FRM_PAUSED));

    // R8
    deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s_i |=> (st == FRM_IDLE));

    // R3
    no_start_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == FRM_IDLE && !hold_s_i) |=> (st == FRM_IDLE));

endmodule

// File: rtl/spi_hold_ctrl.sv
// Module: top of the SPI hold-condition controller.
// Does: synchronises the pins, detects serial clock edges, runs the pause state
// machine and gates the shifter strobes and the data-out enable.
// Assumes: clk is several times faster than the serial clock so that every
// serial clock phase is seen for at least one full cycle after synchronisation.
module spi_hold_ctrl
    import spi_hold_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_i,
    input  logic sck_i,
    input  logic hold_n_i,
    input  logic so_data_i,
    output logic shift_en_o,
    output logic sck_rise_o,
    output logic sck_fall_o,
    output logic held_o,
    output logic frame_rst_o,
    output logic so_o,
    output logic so_oe_o
);

    localparam logic [PIN_NUM-1:0] PIN_IDLE = (PIN_NUM'(1) << PIN_CS) | (PIN_NUM'(1) << PIN_HOLD);

    logic [PIN_NUM-1:0] pins_raw, pins_s;
    logic               cs_s, sck_s, hold_s;
    logic               rise_raw, fall_raw;
    frm_state_t         state;
    logic               active;

    assign pins_raw[PIN_CS]   = cs_n_i;
    assign pins_raw[PIN_SCK]  = sck_i;
    assign pins_raw[PIN_HOLD] = hold_n_i;

    spi_hold_sync #(
        .WIDTH   (PIN_NUM),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PIN_IDLE)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pins_raw),
        .q_o   (pins_s)
    );

    assign cs_s   = pins_s[PIN_CS];
    assign sck_s  = pins_s[PIN_SCK];
    assign hold_s = pins_s[PIN_HOLD];

    spi_hold_sck_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .sck_s_i (sck_s),
        .rise_o  (rise_raw),
        .fall_o  (fall_raw)
    );

    spi_hold_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_s_i   (cs_s),
        .sck_s_i  (sck_s),
        .hold_s_i (hold_s),
        .state_o  (state)
    );

    // Output gating: strobes and enables only in an active, unpaused frame.
    always_comb begin
        active      = (state == FRM_ACTIVE);
        shift_en_o  = active;
        so_oe_o     = active;
        sck_rise_o  = rise_raw & active;
        sck_fall_o  = fall_raw & active;
        held_o      = (state == FRM_PAUSED);
        frame_rst_o = cs_s & (state != FRM_IDLE);
        so_o        = so_data_i & active;
    end

    // R8
    frame_rst_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_rst_o |=> !frame_rst_o);

    // R6
    paused_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (held_o && !cs_s && !hold_s) |=> (!sck_rise_o && !sck_fall_o && !so_oe_o));

endmodule

// File: tb/spi_hold_ctrl_tb.sv
module spi_hold_ctrl_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, hold_n = 1'b1, so_data = 1'b0;
    logic shift_en, sck_rise, sck_fall, held, frame_rst, so, so_oe;

    int checks = 0, fails = 0;
    int n_rise = 0, n_fall = 0, n_frst = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    spi_hold_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sck_i(sck), .hold_n_i(hold_n),
        .so_data_i(so_data), .shift_en_o(shift_en), .sck_rise_o(sck_rise),
        .sck_fall_o(sck_fall), .held_o(held), .frame_rst_o(frame_rst),
        .so_o(so), .so_oe_o(so_oe)
    );

    // Count strobes away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (sck_rise)  n_rise++;
            if (sck_fall)  n_fall++;
            if (frame_rst) n_frst++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input string what, input int act, input int exp);
        chk(act == exp, req, what, act, exp);
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    task automatic t_reset();
        chk_eq("R1", "shift_en", int'(shift_en), 0);
        chk_eq("R1", "so_oe", int'(so_oe), 0);
        chk_eq("R1", "held", int'(held), 0);
        chk_eq("R1", "strobes+frame_rst", n_rise + n_fall + n_frst, 0);
    endtask

    task automatic t_frame();
        int r0, f0;
        cs_n = 1'b0; hold_n = 1'b1; sck = 1'b0; so_data = 1'b1;
        settle();
        chk_eq("R2", "shift_en", int'(shift_en), 1);
        chk_eq("R2", "so_oe", int'(so_oe), 1);
        chk_eq("R9", "so follows data 1", int'(so), 1);
        so_data = 1'b0; @(negedge clk);
        chk_eq("R9", "so follows data 0", int'(so), 0);
        r0 = n_rise; f0 = n_fall;
        for (int i = 0; i < 4; i++) begin
            sck = 1'b1; settle();
            sck = 1'b0; settle();
        end
        chk_eq("R2", "rise strobes", n_rise - r0, 4);
        chk_eq("R2", "fall strobes", n_fall - f0, 4);
    endtask

    task automatic t_pause_low();
        int r0, f0;
        so_data = 1'b1;
        hold_n = 1'b0; settle();
        chk_eq("R4", "held", int'(held), 1);
        chk_eq("R4", "shift_en", int'(shift_en), 0);
        chk_eq("R4", "so_oe", int'(so_oe), 0);
        chk_eq("R9", "so gated", int'(so), 0);
        r0 = n_rise; f0 = n_fall;
        for (int i = 0; i < 3; i++) begin
            sck = 1'b1; settle();
            sck = 1'b0; settle();
        end
        chk_eq("R6", "strobes in pause", (n_rise - r0) + (n_fall - f0), 0);
        chk_eq("R4", "held persists", int'(held), 1);
        hold_n = 1'b1; settle();
        chk_eq("R7", "held after release", int'(held), 0);
        chk_eq("R7", "shift_en after release", int'(shift_en), 1);
    endtask

    task automatic t_pause_deferred();
        int r0, f0;
        sck = 1'b1; settle();
        r0 = n_rise; f0 = n_fall;
        hold_n = 1'b0; settle();
        chk_eq("R5", "held deferred", int'(held), 0);
        chk_eq("R5", "shift_en while high", int'(shift_en), 1);
        sck = 1'b0; settle();
        chk_eq("R5", "held after sck low", int'(held), 1);
        chk_eq("R5", "ending fall strobe", n_fall - f0, 1);
        sck = 1'b1; settle();
        chk_eq("R6", "rise in pause", n_rise - r0, 0);
        hold_n = 1'b1; settle();
        chk_eq("R7", "held until sck low", int'(held), 1);
        sck = 1'b0; settle();
        chk_eq("R7", "released at sck low", int'(held), 0);
        chk_eq("R7", "no fall strobe on exit edge", n_fall - f0, 1);
        sck = 1'b1; settle();
        chk_eq("R7", "next rise counted", n_rise - r0, 1);
        sck = 1'b0; settle();
    endtask

    task automatic t_deselect_paused();
        int k0, r0, f0;
        hold_n = 1'b0; settle();
        chk_eq("R4", "held before deselect", int'(held), 1);
        k0 = n_frst;
        cs_n = 1'b1; settle();
        chk_eq("R8", "frame_rst pulses", n_frst - k0, 1);
        chk_eq("R8", "held cleared", int'(held), 0);
        chk_eq("R8", "so_oe cleared", int'(so_oe), 0);
        cs_n = 1'b0; settle();
        chk_eq("R3", "no start with hold low", int'(shift_en), 0);
        r0 = n_rise; f0 = n_fall;
        sck = 1'b1; settle(); sck = 1'b0; settle();
        chk_eq("R3", "no strobes before start", (n_rise - r0) + (n_fall - f0), 0);
        hold_n = 1'b1; settle();
        chk_eq("R3", "start after release", int'(shift_en), 1);
    endtask

    task automatic t_deselect_active();
        int k0;
        k0 = n_frst;
        cs_n = 1'b1; settle();
        chk_eq("R8", "frame_rst from active", n_frst - k0, 1);
        chk_eq("R8", "shift_en cleared", int'(shift_en), 0);
        repeat (10) @(negedge clk);
        chk_eq("R8", "no pulse while idle", n_frst - k0, 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        settle();
        t_reset();
        t_frame();
        t_pause_low();
        t_pause_deferred();
        t_deselect_paused();
        t_deselect_active();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            summary();
            $finish;
        end
    end

endmodule